// File: doc/BRIEF.md
# PCIe Unsupported Request Screen

This block sits behind the receive header parser of a PCIe endpoint. For each decoded request or completion header it decides whether the packet must be rejected as an Unsupported Request (UR). The parser presents the header fields together with a one-cycle `hdr_vld` strobe. The block also takes the endpoint's configured routing ID, the set of implemented functions, the BAR windows and the memory-space enable bit.

One cycle after the strobe the block returns one verdict. The packet is either accepted, so it can be forwarded to the application, or dropped. A dropped packet always raises the UR error pulse. When the dropped packet was a non-posted request, the block also raises a request for a UR-status completion, which a separate completion generator serves.

Encodings used throughout (fmt is 3 bits, type is 5 bits):

| Packet | fmt | type |
|---|---|---|
| memory read | 000 or 001 | 00000 |
| memory write | 010 or 011 | 00000 |
| locked memory read | 000 or 001 | 00001 |
| I/O read / write | 000 / 010 | 00010 |
| type 0 config read / write | 000 / 010 | 00100 |
| type 1 config read / write | 000 / 010 | 00101 |
| completion without / with data | 000 / 010 | 01010 |
| locked completion without / with data | 000 / 010 | 01011 |
| message | 001 or 011 | 10xxx |

fmt bit 0 set means a 4-DW header with a 64-bit address.

Top module: `pcie_ur_screen`

## Requirements
- R1: One clock after each cycle with `hdr_vld` high, exactly one of `acc_vld` or `drop_vld` is high for a single cycle. With `hdr_vld` low, neither is high in the next cycle. Messages (fmt 001/011, type 10xxx) are never dropped.
- R2: A type 0 config request (type 00100) is dropped when its target function number `hdr_dst_func` is at or above `NUM_FUNC`, or when the matching bit of `func_present` is 0.
- R3: Every type 1 config request (type 00101) is dropped.
- R4: A locked memory read (type 00001) is dropped, and so is every locked completion (type 01011).
- R5: A memory read or write with a 4-DW header (fmt bit 0 set) whose address bits 63:32 are all zero is dropped.
- R6: A memory or I/O request is dropped unless some BAR i has `bar_on[i]`=1, `bar_is_io[i]` equal to the request's I/O-ness, and `(addr ^ base_i) & mask_i` = 0. For 3-DW headers, address bits 63:32 count as zero.
- R7: Every memory request (types 00000 and 00001) is dropped while `mem_space_en` (command register bit 1) is 0.
- R8: A type 0 config write (fmt 010, type 00100) with `hdr_poison`=1 is dropped.
- R9: A completion, locked or not, whose `hdr_req_id` differs from `own_id` is dropped.
- R10: `ur_err` pulses with every drop. `ur_cpl_req` pulses with a drop only when the packet was non-posted, meaning a read, an I/O or config access, or a locked read. It never pulses for memory writes, messages or completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_vld | input | 1 | Header fields valid this cycle |
| hdr_fmt | input | 3 | Header format field |
| hdr_type | input | 5 | Header type field |
| hdr_addr | input | 64 | Request address (bits 63:32 zero for 3-DW headers) |
| hdr_req_id | input | 16 | Requester ID carried by a completion |
| hdr_dst_func | input | 3 | Target function number of a config request |
| hdr_poison | input | 1 | Poisoned-data bit of the header |
| own_id | input | 16 | Endpoint's configured bus/device/function |
| func_present | input | NUM_FUNC | One bit per implemented function |
| bar_base | input | NUM_BAR*64 | BAR base addresses, BAR i at bits 64*i+63:64*i |
| bar_mask | input | NUM_BAR*64 | BAR compare masks, same layout |
| bar_on | input | NUM_BAR | BAR is implemented and enabled |
| bar_is_io | input | NUM_BAR | BAR decodes I/O space rather than memory |
| mem_space_en | input | 1 | Memory space enable from the command register |
| acc_vld | output | 1 | Header accepted |
| drop_vld | output | 1 | Header dropped |
| ur_err | output | 1 | Unsupported Request error pulse |
| ur_cpl_req | output | 1 | Request to send a UR-status completion |

## Verification
Many rules overlap, so a typical random packet that breaks one rule usually breaks others too. The rules that are hardest to see alone are the zero-upper-address rule and the BAR miss rule. A 4-DW read that is rejected only because its upper address bits are zero must still land inside an enabled memory BAR. The bench reaches this with a BAR placed below 4 GB and a 4-DW read aimed into it. Directed cases also make a single BAR fail on its type bit or its enable bit while the address compare matches. Random traffic then mixes all packet kinds with biased choices of address, requester ID, poison and enable. This covers the overlaps, and a reference model checks every verdict.

// File: rtl/pcie_ur_screen.sv
module pcie_ur_screen #(
  parameter int NUM_FUNC = 4,
  parameter int NUM_BAR  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hdr_vld,
  input  logic [2:0]             hdr_fmt,
  input  logic [4:0]             hdr_type,
  input  logic [63:0]            hdr_addr,
  input  logic [15:0]            hdr_req_id,
  input  logic [2:0]             hdr_dst_func,
  input  logic                   hdr_poison,
  input  logic [15:0]            own_id,
  input  logic [NUM_FUNC-1:0]    func_present,
  input  logic [NUM_BAR*64-1:0]  bar_base,
  input  logic [NUM_BAR*64-1:0]  bar_mask,
  input  logic [NUM_BAR-1:0]     bar_on,
  input  logic [NUM_BAR-1:0]     bar_is_io,
  input  logic                   mem_space_en,
  output logic                   acc_vld,
  output logic                   drop_vld,
  output logic                   ur_err,
  output logic                   ur_cpl_req
);

  logic no_prefix, wide, has_data;
  assign no_prefix = !hdr_fmt[2];
  assign wide      = hdr_fmt[0];
  assign has_data  = hdr_fmt[1];

  logic is_mem, is_mrdlk, is_io, is_cfg0, is_cfg1, is_cpl, is_cpl_lk, is_msg;
  assign is_mem    = no_prefix && (hdr_type == 5'b00000 || hdr_type == 5'b00001);
  assign is_mrdlk  = is_mem && hdr_type[0] && !has_data;
  assign is_io     = no_prefix && !wide && hdr_type == 5'b00010;
  assign is_cfg0   = no_prefix && !wide && hdr_type == 5'b00100;
  assign is_cfg1   = no_prefix && !wide && hdr_type == 5'b00101;
  assign is_cpl    = no_prefix && !wide && hdr_type[4:1] == 4'b0101;
  assign is_cpl_lk = is_cpl && hdr_type[0];
  assign is_msg    = no_prefix && wide && hdr_type[4:3] == 2'b10;

  logic posted;
  assign posted = (is_mem && has_data) || is_msg;

  logic [63:0] eff_addr;
  assign eff_addr = wide ? hdr_addr : {32'h0, hdr_addr[31:0]};

  logic [NUM_BAR-1:0] bar_hit;
  for (genvar g = 0; g < NUM_BAR; g++) begin : g_bar
    assign bar_hit[g] = bar_on[g] && (bar_is_io[g] == is_io) &&
                        (((eff_addr ^ bar_base[64*g +: 64]) & bar_mask[64*g +: 64]) == 64'h0);
  end

  logic [7:0] fn_map;
  for (genvar f = 0; f < 8; f++) begin : g_fn
    if (f < NUM_FUNC) begin : g_real
      assign fn_map[f] = func_present[f];
    end else begin : g_none
      assign fn_map[f] = 1'b0;
    end
  end

  logic [7:0] rule;
  assign rule[0] = is_cfg0 && !fn_map[hdr_dst_func];
  assign rule[1] = is_cfg1;
  assign rule[2] = is_mrdlk || is_cpl_lk;
  assign rule[3] = is_mem && wide && hdr_addr[63:32] == 32'h0;
  assign rule[4] = (is_mem || is_io) && bar_hit == '0;
  assign rule[5] = is_mem && !mem_space_en;
  assign rule[6] = is_cfg0 && has_data && hdr_poison;
  assign rule[7] = is_cpl && hdr_req_id != own_id;

  logic reject;
  assign reject = |rule;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_vld    <= 1'b0;
      drop_vld   <= 1'b0;
      ur_err     <= 1'b0;
      ur_cpl_req <= 1'b0;
    end else begin
      acc_vld    <= hdr_vld && !reject;
      drop_vld   <= hdr_vld && reject;
      ur_err     <= hdr_vld && reject;
      ur_cpl_req <= hdr_vld && reject && !posted && !is_cpl;
    end
  end

  p_one_verdict_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld |=> $countones({acc_vld, drop_vld}) == 1);
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_vld |=> !acc_vld && !drop_vld);
  p_msg_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld && is_msg |=> acc_vld);
  p_type1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld && is_cfg1 |=> drop_vld && ur_cpl_req);
  p_mse_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld && is_mem && !mem_space_en |=> drop_vld);
  p_cpl_id_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld && is_cpl && hdr_req_id != own_id |=> drop_vld && !ur_cpl_req);
  p_posted_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld && posted |=> !ur_cpl_req);
  p_cpl_with_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ur_cpl_req |-> drop_vld && ur_err);

endmodule

// File: tb/pcie_ur_screen_tb.sv
`timescale 1ns/1ps
module pcie_ur_screen_tb;
  localparam int NF = 4;
  localparam int NB = 3;

  logic clk = 0, rst_n = 0, hdr_vld = 0, hdr_poison = 0, mem_space_en = 1;
  logic [2:0] hdr_fmt = 0, hdr_dst_func = 0;
  logic [4:0] hdr_type = 0;
  logic [63:0] hdr_addr = 0;
  logic [15:0] hdr_req_id = 0, own_id = 16'h3A10;
  logic [NF-1:0] func_present = 4'b1011;
  logic [NB*64-1:0] bar_base, bar_mask;
  logic [NB-1:0] bar_on = '1, bar_is_io = 3'b100;
  logic acc_vld, drop_vld, ur_err, ur_cpl_req;

  int checks = 0, errors = 0;
  bit done = 0;

  pcie_ur_screen #(.NUM_FUNC(NF), .NUM_BAR(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .hdr_fmt(hdr_fmt), .hdr_type(hdr_type),
    .hdr_addr(hdr_addr), .hdr_req_id(hdr_req_id), .hdr_dst_func(hdr_dst_func),
    .hdr_poison(hdr_poison), .own_id(own_id), .func_present(func_present),
    .bar_base(bar_base), .bar_mask(bar_mask), .bar_on(bar_on), .bar_is_io(bar_is_io),
    .mem_space_en(mem_space_en), .acc_vld(acc_vld), .drop_vld(drop_vld),
    .ur_err(ur_err), .ur_cpl_req(ur_cpl_req));

  always #2.5 clk = ~clk;

  typedef enum int {MRD32, MRD64, MWR32, MWR64, MRDLK, IORD, IOWR, CFGRD0, CFGWR0,
                    CFGRD1, CFGWR1, CPL, CPLD, CPLLK, CPLDLK, MSG, MSGD, NKIND} kind_t;

  function automatic logic [7:0] enc(kind_t k);
    case (k)
      MRD32:  return {3'b000, 5'b00000};
      MRD64:  return {3'b001, 5'b00000};
      MWR32:  return {3'b010, 5'b00000};
      MWR64:  return {3'b011, 5'b00000};
      MRDLK:  return {3'b000, 5'b00001};
      IORD:   return {3'b000, 5'b00010};
      IOWR:   return {3'b010, 5'b00010};
      CFGRD0: return {3'b000, 5'b00100};
      CFGWR0: return {3'b010, 5'b00100};
      CFGRD1: return {3'b000, 5'b00101};
      CFGWR1: return {3'b010, 5'b00101};
      CPL:    return {3'b000, 5'b01010};
      CPLD:   return {3'b010, 5'b01010};
      CPLLK:  return {3'b000, 5'b01011};
      CPLDLK: return {3'b010, 5'b01011};
      MSG:    return {3'b001, 5'b10100};
      default: return {3'b011, 5'b10000};
    endcase
  endfunction

  function automatic bit in_bar(kind_t k, logic [63:0] a);
    bit io = (k == IORD || k == IOWR);
    for (int i = 0; i < NB; i++)
      if (bar_on[i] && bar_is_io[i] == io &&
          ((a ^ bar_base[64*i +: 64]) & bar_mask[64*i +: 64]) == 0) return 1;
    return 0;
  endfunction

  // returns {drop, cpl_owed}
  function automatic logic [1:0] model(kind_t k, logic [63:0] a, logic [15:0] rid,
                                       logic [2:0] fn, logic ep);
    bit mem = k inside {MRD32, MRD64, MWR32, MWR64, MRDLK};
    bit drop = 0;
    if ((k == CFGRD0 || k == CFGWR0) && (fn >= NF || !func_present[fn])) drop = 1; // R2
    if (k == CFGRD1 || k == CFGWR1) drop = 1;                                       // R3
    if (k == MRDLK || k == CPLLK || k == CPLDLK) drop = 1;                          // R4
    if ((k == MRD64 || k == MWR64) && a[63:32] == 0) drop = 1;                      // R5
    if ((mem || k == IORD || k == IOWR) && !in_bar(k, a)) drop = 1;                 // R6
    if (mem && !mem_space_en) drop = 1;                                             // R7
    if (k == CFGWR0 && ep) drop = 1;                                                // R8
    if (k inside {CPL, CPLD, CPLLK, CPLDLK} && rid != own_id) drop = 1;             // R9
    return {drop, drop && !(k inside {MWR32, MWR64, MSG, MSGD, CPL, CPLD, CPLLK, CPLDLK})};
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {acc,drop,err,cpl} actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic send(string tag, kind_t k, logic [63:0] a, logic [15:0] rid,
                      logic [2:0] fn, logic ep);
    logic [1:0] m;
    logic [7:0] e = enc(k);
    m = model(k, a, rid, fn, ep);
    {hdr_fmt, hdr_type} = e;
    hdr_addr = a; hdr_req_id = rid; hdr_dst_func = fn; hdr_poison = ep; hdr_vld = 1;
    @(negedge clk);
    hdr_vld = 0;
    check(tag, {acc_vld, drop_vld, ur_err, ur_cpl_req}, {!m[1], m[1], m[1], m[0]});
  endtask

  initial begin
    bar_base = {64'h0000_0000_0000_1000, 64'h0000_0012_0000_0000, 64'h0000_0000_8000_0000};
    bar_mask = {64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_FFFF_FFF0_0000, 64'hFFFF_FFFF_FFFF_F000};
    repeat (3) @(negedge clk);
    check("R1 reset", {acc_vld, drop_vld, ur_err, ur_cpl_req}, 4'b0000);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle", {acc_vld, drop_vld, ur_err, ur_cpl_req}, 4'b0000);
    send("R1 mem read hit", MRD32, 64'h8000_0040, own_id, 0, 0);
    send("R1 message accepted", MSG, 64'h0, own_id, 0, 0);
    send("R1 message with data", MSGD, 64'h0, own_id, 0, 1);
    send("R2 cfg0 absent fn2", CFGRD0, 0, own_id, 3'd2, 0);
    send("R2 cfg0 fn above range", CFGRD0, 0, own_id, 3'd6, 0);
    send("R2 cfg0 present fn3", CFGRD0, 0, own_id, 3'd3, 0);
    send("R3 type1 read", CFGRD1, 0, own_id, 0, 0);
    send("R3 type1 write", CFGWR1, 0, own_id, 0, 0);
    send("R4 locked read in bar", MRDLK, 64'h8000_0100, own_id, 0, 0);
    send("R4 locked cpl own id", CPLLK, 0, own_id, 0, 0);
    send("R4 locked cpld own id", CPLDLK, 0, own_id, 0, 0);
    send("R5 4dw read upper zero in bar", MRD64, 64'h8000_0010, own_id, 0, 0);
    send("R5 4dw write upper zero", MWR64, 64'h8000_0010, own_id, 0, 0);
    send("R5 4dw read 64b bar", MRD64, 64'h12_000A_BC00, own_id, 0, 0);
    send("R6 mem read miss", MRD32, 64'h9000_0000, own_id, 0, 0);
    send("R6 io read hit", IORD, 64'h1044, own_id, 0, 0);
    send("R6 io write miss", IOWR, 64'h2044, own_id, 0, 0);
    send("R6 io address in mem bar", IORD, 64'h8000_0000, own_id, 0, 0);
    bar_on[0] = 0;
    send("R6 disabled bar", MRD32, 64'h8000_0040, own_id, 0, 0);
    bar_on[0] = 1;
    mem_space_en = 0;
    send("R7 mse off read", MRD32, 64'h8000_0040, own_id, 0, 0);
    send("R7 mse off write", MWR64, 64'h12_0000_0000, own_id, 0, 0);
    send("R7 io unaffected", IORD, 64'h1000, own_id, 0, 0);
    mem_space_en = 1;
    send("R8 poisoned cfg0 write", CFGWR0, 0, own_id, 3'd0, 1);
    send("R8 poisoned cfg0 read", CFGRD0, 0, own_id, 3'd0, 1);
    send("R9 cpl wrong id", CPL, 0, 16'h3A11, 0, 0);
    send("R9 cpld own id", CPLD, 0, own_id, 0, 0);
    send("R10 mem write miss posted", MWR32, 64'h0, own_id, 0, 0);
    @(negedge clk);
    check("R1 idle after traffic", {acc_vld, drop_vld, ur_err, ur_cpl_req}, 4'b0000);

    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 3000; n++) begin
      kind_t k = kind_t'($urandom_range(0, NKIND - 1));
      logic [63:0] a;
      logic [15:0] rid = ($urandom_range(0, 3) != 0) ? own_id : 16'($urandom);
      int sel = $urandom_range(0, 3);
      a = {$urandom, $urandom};
      if (sel == 0) a = 64'h8000_0000 | 64'($urandom_range(0, 4095));
      if (sel == 1) a = 64'h12_0000_0000 | 64'($urandom_range(0, 1048575));
      if (sel == 2) a = 64'h1000 | 64'($urandom_range(0, 255));
      if (!(k == MRD64 || k == MWR64)) a[63:32] = 0;
      mem_space_en = ($urandom_range(0, 9) != 0);
      send("R10 random", k, a, rid, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 3) == 0));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule